// File: doc/BRIEF.md
# Bidirectional latch-register bus transceiver

This block moves a data word between two ports, A and B, in both directions at once. Each direction has one storage element. In a given system cycle it acts either as a transparent latch or as a register that loads on the falling edge of that direction's own strobe. Every direction has its own four controls: a latch enable, a strobe, an active-low strobe qualifier and an active-low drive enable. Data passes through unchanged, with no inversion.

The strobe inputs are treated as plain data. A single system clock samples each one, and a falling edge is detected by comparing the current sample with the previous one. This keeps the whole block synchronous. Each output port presents a data vector and a drive bit, so an enclosing level can form a three-state pin with a conditional assignment.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: The word width is the parameter WIDTH, default 18. Each output word carries its input word bit for bit, with no inversion and no reordering.
- R2: While a direction's latch enable is 1, its output data equals its input data in the same cycle, combinationally.
- R3: While the latch enable is 0 and no qualified falling strobe edge is seen, the output data holds its stored value, whatever the input does.
- R4: A strobe falling edge is seen on a system clock edge where the strobe samples 0 and its previous sample was 1. If the latch enable and the qualifier are both 0 at that edge, the input sampled at that edge is stored and appears at the output from the next cycle.
- R5: When the active-low qualifier is 1, a falling strobe edge leaves the stored value unchanged.
- R6: While the latch enable is 1, storage loads the input on every system clock edge. After the enable falls, the output shows the input that was sampled at the last edge where the enable was still 1.
- R7: The drive bit of an output port is 1 exactly when that direction's active-low output enable is 0 and reset is released. Otherwise the port is released.
- R8: The A-to-B path (A input to B output) and the B-to-A path (B input to A output) never affect each other.
- R9: A rising strobe edge never changes the stored value.
- R10: During reset both drive bits are 0. Storage resets to zero, and a strobe that was already high at reset release does not count as a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Word received from port A |
| a_out | output | WIDTH | Word presented toward port A |
| a_drv | output | 1 | Drive enable for port A |
| b_in | input | WIDTH | Word received from port B |
| b_out | output | WIDTH | Word presented toward port B |
| b_drv | output | 1 | Drive enable for port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B strobe, loads on its falling edge |
| ab_qual_n | input | 1 | A-to-B strobe qualifier, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A strobe, loads on its falling edge |
| ba_qual_n | input | 1 | B-to-A strobe qualifier, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The latch enable can fall in the same system cycle that the strobe falls. In that case both the retain-on-close rule and the edge capture claim the storage at one edge. The bench provokes this by dropping both signals together and changing the input word at the same moment. It then expects the old transparent word right after the change and the new input word one edge later, which shows that the edge capture wins. The same-cycle interplay of a falling edge and a blocking qualifier is judged the same way, against a word that must stay put.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;
    localparam int unsigned DIR_AB = 0;
    localparam int unsigned DIR_BA = 1;
    localparam int unsigned N_DIR  = 2;

    typedef enum logic [1:0] {
        LD_HOLD    = 2'd0,
        LD_FOLLOW  = 2'd1,
        LD_CAPTURE = 2'd2
    } load_e;
endpackage

// File: rtl/bxcvr_fall_sense.sv
module bxcvr_fall_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic fall
);
    typedef struct packed {
        logic last;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.last = stb;
        fall     = s_q.last & ~stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bxcvr_hold_reg.sv
module bxcvr_hold_reg
    import bxcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  load_e            sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        unique case (sel)
            LD_FOLLOW:  h_d.word = din;
            LD_CAPTURE: h_d.word = din;
            default:    h_d.word = h_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign q = h_q.word;
endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane
    import bxcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             stb,
    input  logic             qual_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             drv
);
    logic             fall;
    load_e            sel;
    logic [WIDTH-1:0] held;

    bxcvr_fall_sense u_sense (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (stb),
        .fall (fall)
    );

    always_comb begin
        if (le)                  sel = LD_FOLLOW;
        else if (fall & ~qual_n) sel = LD_CAPTURE;
        else                     sel = LD_HOLD;
    end

    bxcvr_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (sel),
        .din  (din),
        .q    (held)
    );

    assign dout = le ? din : held;
    assign drv  = ~oe_n & rst_n;
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import bxcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv,
    input  logic             ab_le,
    input  logic             ab_stb,
    input  logic             ab_qual_n,
    input  logic             ab_oe_n,
    input  logic             ba_le,
    input  logic             ba_stb,
    input  logic             ba_qual_n,
    input  logic             ba_oe_n
);
    logic [WIDTH-1:0] l_in   [N_DIR];
    logic [WIDTH-1:0] l_out  [N_DIR];
    logic             l_drv  [N_DIR];
    logic             l_le   [N_DIR];
    logic             l_stb  [N_DIR];
    logic             l_qual [N_DIR];
    logic             l_oe   [N_DIR];

    assign l_in[DIR_AB]   = a_in;
    assign l_le[DIR_AB]   = ab_le;
    assign l_stb[DIR_AB]  = ab_stb;
    assign l_qual[DIR_AB] = ab_qual_n;
    assign l_oe[DIR_AB]   = ab_oe_n;

    assign l_in[DIR_BA]   = b_in;
    assign l_le[DIR_BA]   = ba_le;
    assign l_stb[DIR_BA]  = ba_stb;
    assign l_qual[DIR_BA] = ba_qual_n;
    assign l_oe[DIR_BA]   = ba_oe_n;

    for (genvar g = 0; g < N_DIR; g++) begin : g_lane
        bxcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (l_in[g]),
            .le    (l_le[g]),
            .stb   (l_stb[g]),
            .qual_n(l_qual[g]),
            .oe_n  (l_oe[g]),
            .dout  (l_out[g]),
            .drv   (l_drv[g])
        );
    end

    assign b_out = l_out[DIR_AB];
    assign b_drv = l_drv[DIR_AB];
    assign a_out = l_out[DIR_BA];
    assign a_drv = l_drv[DIR_BA];
endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drv,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drv,
    input logic             ab_le,
    input logic             ab_stb,
    input logic             ab_qual_n,
    input logic             ab_oe_n,
    input logic             ba_le,
    input logic             ba_stb,
    input logic             ba_qual_n,
    input logic             ba_oe_n
);
    // R2: transparent path follows input
    a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in));
    a_r2_ba_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in));

    // R3: no qualified fall, closed latch, value stays
    a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !($past(ab_stb) && !ab_stb && !ab_qual_n))
        |=> (ab_le || $stable(b_out)));

    // R4: qualified fall stores the sampled input
    a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(rst_n) && $past(ab_stb) && !ab_stb && !ab_qual_n)
        |=> (ab_le || b_out == $past(a_in)));
    a_r4_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && $past(rst_n) && $past(ba_stb) && !ba_stb && !ba_qual_n)
        |=> (ba_le || a_out == $past(b_in)));

    // R5: blocked qualifier keeps the word
    a_r5_ab_qual_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_qual_n) |=> (ab_le || b_out == $past(b_out)));

    // R7: released enable means no drive
    a_r7_ab_release: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> !b_drv);
    a_r7_ba_release: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> !a_drv);

    // R10: nothing drives during reset
    always_comb begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!a_drv && !b_drv);
        end
    end
endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_le(ab_le), .ab_stb(ab_stb), .ab_qual_n(ab_qual_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_stb(ba_stb), .ba_qual_n(ba_qual_n), .ba_oe_n(ba_oe_n)
);

// File: tb/bidir_latch_xcvr_tb_top.sv
module bidir_latch_xcvr_tb_top;
    localparam int unsigned W = 18;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
    logic         a_drv, b_drv;
    logic ab_le = 0, ab_stb = 0, ab_qual_n = 0, ab_oe_n = 1;
    logic ba_le = 0, ba_stb = 0, ba_qual_n = 0, ba_oe_n = 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_le(ab_le), .ab_stb(ab_stb), .ab_qual_n(ab_qual_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_stb(ba_stb), .ba_qual_n(ba_qual_n), .ba_oe_n(ba_oe_n)
    );

    task automatic check_w(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check_w("R10 drive bits in reset", {16'd0, a_drv, b_drv}, '0);
        ab_oe_n = 0; ba_oe_n = 0; ab_stb = 1; ba_stb = 1;
        #1;
        check_w("R10 drive bits in reset with enable", {16'd0, a_drv, b_drv}, '0);
        @(negedge clk); rst_n = 1;
        ab_stb = 0; ba_stb = 0; a_in = 18'h1F0F0;
        tick();
        check_w("R10 storage zero, high strobe at release not an edge", b_out, '0);
        check_w("R10 A side storage zero", a_out, '0);
    endtask

    task automatic t_transparent();
        ab_le = 1; a_in = 18'h2AAAA; #1;
        check_w("R1 R2 bit-exact follow", b_out, 18'h2AAAA);
        a_in = 18'h15555; #1;
        check_w("R2 follow without clock", b_out, 18'h15555);
        tick();
    endtask

    task automatic t_close();
        a_in = 18'h0ABCD; tick();
        ab_le = 0; a_in = 18'h31111; #1;
        check_w("R6 retains last transparent word", b_out, 18'h0ABCD);
        tick(); a_in = 18'h02222; tick();
        check_w("R3 hold with changing input", b_out, 18'h0ABCD);
    endtask

    task automatic t_capture();
        ab_stb = 1; tick();
        a_in = 18'h12345; ab_stb = 0; tick();
        check_w("R4 falling edge capture", b_out, 18'h12345);
        a_in = 18'h3FFFF; tick(); tick();
        check_w("R3 hold after capture", b_out, 18'h12345);
        ab_stb = 1; tick(); tick();
        check_w("R9 rising edge ignored", b_out, 18'h12345);
    endtask

    task automatic t_qualifier();
        ab_qual_n = 1; a_in = 18'h0F00F; ab_stb = 0; tick();
        check_w("R5 blocked edge keeps word", b_out, 18'h12345);
        ab_qual_n = 0; ab_stb = 1; tick();
        ab_stb = 0; tick();
        check_w("R5 edge accepted once unblocked", b_out, 18'h0F00F);
    endtask

    task automatic t_same_cycle();
        ab_le = 1; ab_stb = 1; a_in = 18'h06666; tick();
        ab_le = 0; ab_stb = 0; a_in = 18'h39999; #1;
        check_w("R6 closed latch shows old word", b_out, 18'h06666);
        tick();
        check_w("R4 edge with closing latch captures new word", b_out, 18'h39999);
    endtask

    task automatic t_drive();
        ab_oe_n = 1; #1;
        check_w("R7 released port", {17'd0, b_drv}, '0);
        ab_oe_n = 0; #1;
        check_w("R7 driven port", {17'd0, b_drv}, 18'd1);
        check_w("R7 driven data", b_out, 18'h39999);
    endtask

    task automatic t_independent();
        ba_stb = 1; tick();
        b_in = 18'h2C3C3; ba_stb = 0; a_in = 18'h00001; tick();
        check_w("R8 B-to-A capture", a_out, 18'h2C3C3);
        check_w("R8 A-to-B untouched", b_out, 18'h39999);
        ba_oe_n = 1; #1;
        check_w("R8 B-to-A release leaves A-to-B drive", {16'd0, a_drv, b_drv}, 18'd1);
        ba_le = 1; b_in = 18'h1E1E1; #1;
        check_w("R8 R2 B-to-A transparent", a_out, 18'h1E1E1);
        check_w("R8 A-to-B still held", b_out, 18'h39999);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_close();
        t_capture();
        t_qualifier();
        t_same_cycle();
        t_drive();
        t_independent();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule